// File: doc/BRIEF.md
# Erase-Verify Command Sequencer for a Nonvolatile Word Array

This block is the command front end of a small nonvolatile word store. It runs one command: a blank check that walks every word of the array and reports whether all of them are erased. An erased word reads as all ones. Software launches the command with three bus writes. The first is a write into the array space, whose data is discarded. The second puts the command code into the command register. The third writes a one to the buffer-empty status flag, which clears that flag and starts the command.

Execution time is fixed. For an array with no programmed words, completion comes exactly `WORDS + OVH` cycles after the launch edge, where `OVH` is 14. If the walk meets a word that is not all ones, it stops there and reports after `OVH` plus the number of words it examined, with the blank flag left clear. A second command can be buffered while one is running. In that case the first command ends without raising the complete flag, and the buffered one starts on the same edge.

The array is a register file inside the block. A preload port lets a test environment plant programmed words.

Top module: `eeverify_ctrl`

## Requirements
- R1: After reset, stat_buf_empty and stat_done are 1, and stat_blank and stat_acc_err are 0.
- R2: A launch is a write with bus_sel=2'b00 (array, data ignored), then a write with bus_sel=2'b01 and bus_wdata=8'h05, then a write with bus_sel=2'b10 and bus_wdata[7]=1. On the edge that takes the third write, stat_buf_empty, stat_done and stat_blank all go to 0.
- R3: With every word equal to all ones, stat_done rises exactly WORDS+14 cycles after the launch edge, and stat_blank is then 1.
- R4: If the lowest-index word that is not all ones sits at index i, stat_done rises exactly 14+i+1 cycles after the launch edge, stat_blank stays 0, and no word above i is examined.
- R5: When the scanner is idle at launch, stat_buf_empty returns to 1 one cycle after the launch edge.
- R6: A sequence completed while a scan is running is held with stat_buf_empty at 0. The running scan then ends without setting stat_done, and the held command starts on that same edge, so stat_done rises 2*(WORDS+14) cycles after the first launch edge.
- R7: A command write (bus_sel=2'b01) that is not directly preceded in the sequence by an array write, or whose code is not 8'h05, changes no sequence state and sets stat_acc_err. A status launch attempted after such a write leaves stat_buf_empty and stat_done unchanged.
- R8: A status write with bus_wdata[7]=0 launches nothing, and status writes made while a scan runs change neither its completion cycle nor its result.
- R9: Writing bus_wdata[4]=1 with bus_sel=2'b10 clears stat_acc_err. Writing 0 in that bit leaves it set.
- R10: Bus writes to the array space never alter array contents.
- R11: A preload write (pre_we, pre_addr, pre_data) replaces the addressed word, and later scans see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_sel | input | 2 | Write target: 00 array, 01 command, 10 status |
| bus_wdata | input | 8 | Write data (command code, or status bits 7 and 4) |
| pre_we | input | 1 | Preload write enable |
| pre_addr | input | $clog2(WORDS) | Preload word index |
| pre_data | input | DW | Preload word value |
| stat_buf_empty | output | 1 | Command buffer free; a write of 1 launches |
| stat_done | output | 1 | Command complete |
| stat_blank | output | 1 | Last completed verify found all words erased |
| stat_acc_err | output | 1 | Illegal command write seen; write-one-to-clear |

## Verification
The bench builds the block with WORDS=8 and the default 14-cycle overhead, so a full scan takes 22 cycles. That is short enough to place the first programmed word at every index in turn and to time each early stop exactly. Running two commands back to back stays within a few dozen cycles, so the hand-off from a finishing scan to a buffered one is timed to the edge. The small array also lets the bench plant and restore words one at a time and check the exact completion cycle against WORDS+14 or 14+i+1.

// File: rtl/eev_pkg.sv
package eev_pkg;

  localparam logic [1:0] SEL_ARRAY = 2'b00;
  localparam logic [1:0] SEL_CMD   = 2'b01;
  localparam logic [1:0] SEL_STAT  = 2'b10;

  localparam logic [7:0] CODE_BLANK_CHECK = 8'h05;

  localparam int unsigned STAT_GO_BIT  = 7;
  localparam int unsigned STAT_ERR_BIT = 4;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_ADDR = 2'd1,
    SQ_CMD  = 2'd2
  } eev_seq_e;

  // cycles from launch edge to completion edge for a given number of examined words
  function automatic int unsigned verify_cycles(input int unsigned words_seen,
                                                input int unsigned overhead);
    return overhead + words_seen;
  endfunction

endpackage

// File: rtl/eev_array.sv
module eev_array #(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned DW    = 16,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] cells [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cells[g] <= '1;
      end else if (pre_we && pre_addr == AW'(g)) begin
        cells[g] <= pre_data;
      end
    end
  end

  always_comb begin
    rd_data = '1;
    for (int k = 0; k < WORDS; k++) begin
      if (rd_addr == AW'(k)) rd_data = cells[k];
    end
  end

endmodule

// File: rtl/eev_scan.sv
module eev_scan
  import eev_pkg::*;
#(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned DW    = 16,
  parameter int unsigned OVH   = 14,
  localparam int unsigned AW   = $clog2(WORDS),
  localparam int unsigned IW   = AW + 1,
  localparam int unsigned CW   = $clog2(WORDS + OVH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          busy,
  output logic          fin,
  output logic          ok
);

  logic [CW-1:0] elapsed;
  logic [CW-1:0] target;
  logic [IW-1:0] idx;
  logic          miss;
  logic          word_check;
  logic          word_erased;

  assign rd_addr     = idx[AW-1:0];
  assign word_check  = busy && !miss && (idx < IW'(WORDS));
  assign word_erased = (rd_data == '1);
  assign fin         = busy && (elapsed == target);
  assign ok          = !miss;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      elapsed <= '0;
      target  <= '0;
      idx     <= '0;
      miss    <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      elapsed <= CW'(1);
      target  <= CW'(verify_cycles(WORDS, OVH));
      idx     <= '0;
      miss    <= 1'b0;
    end else if (fin) begin
      busy <= 1'b0;
    end else if (busy) begin
      elapsed <= elapsed + CW'(1);
      if (word_check) begin
        idx <= idx + IW'(1);
        if (!word_erased) begin
          miss   <= 1'b1;
          target <= CW'(verify_cycles(int'(idx) + 1, OVH));
        end
      end
    end
  end

  AST_SCAN_WITHIN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (elapsed <= target)); // R3
  AST_SCAN_HALTS_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && miss && !start) |=> (idx == $past(idx))); // R4
  AST_SCAN_FIN_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (fin && !start) |=> !busy); // R3

endmodule

// File: rtl/eev_seq.sv
module eev_seq
  import eev_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_wr,
  input  logic [1:0] bus_sel,
  input  logic [7:0] bus_wdata,
  input  logic       scan_busy,
  input  logic       scan_fin,
  input  logic       scan_ok,
  output logic       start,
  output logic       buf_empty,
  output logic       done,
  output logic       blank,
  output logic       acc_err
);

  eev_seq_e state;
  logic     pend;

  logic ev_arr_wr, ev_cmd_wr, ev_stat_wr;
  logic ev_cmd_ok, ev_bad_cmd, ev_launch, ev_take, ev_complete;

  assign ev_arr_wr   = bus_wr && (bus_sel == SEL_ARRAY);
  assign ev_cmd_wr   = bus_wr && (bus_sel == SEL_CMD);
  assign ev_stat_wr  = bus_wr && (bus_sel == SEL_STAT);
  assign ev_cmd_ok   = ev_cmd_wr && (state == SQ_ADDR) && (bus_wdata == CODE_BLANK_CHECK);
  assign ev_bad_cmd  = ev_cmd_wr && !ev_cmd_ok;
  assign ev_launch   = ev_stat_wr && bus_wdata[STAT_GO_BIT] && (state == SQ_CMD) && buf_empty;
  assign ev_take     = pend && scan_fin;
  assign ev_complete = scan_fin && !pend && !ev_launch;
  assign start       = (ev_launch && (!scan_busy || scan_fin)) || ev_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
    end else begin
      unique case (state)
        SQ_IDLE: if (ev_arr_wr && buf_empty) state <= SQ_ADDR;
        SQ_ADDR: if (ev_cmd_ok) state <= SQ_CMD;
        SQ_CMD:  if (ev_launch) state <= SQ_IDLE;
        default: state <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      buf_empty <= 1'b1;
    end else begin
      if (ev_launch)      pend <= scan_busy && !scan_fin;
      else if (ev_take)   pend <= 1'b0;

      if (ev_launch)                buf_empty <= 1'b0;
      else if (!buf_empty && !pend) buf_empty <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b1;
      blank <= 1'b0;
    end else if (ev_launch) begin
      done  <= 1'b0;
      blank <= 1'b0;
    end else if (ev_complete) begin
      done  <= 1'b1;
      blank <= scan_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_err <= 1'b0;
    end else if (ev_bad_cmd) begin
      acc_err <= 1'b1;
    end else if (ev_stat_wr && bus_wdata[STAT_ERR_BIT]) begin
      acc_err <= 1'b0;
    end
  end

  AST_LAUNCH_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_launch |=> (!buf_empty && !done && !blank)); // R2
  AST_REFILL_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_empty && !pend) |=> buf_empty); // R5
  AST_BLANK_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> done); // R3
  AST_HELD_CMD_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (!done && scan_busy)); // R6
  AST_DONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !scan_busy); // R6
  AST_BAD_CMD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bad_cmd |=> (acc_err && $stable(state))); // R7

endmodule

// File: rtl/eeverify_ctrl.sv
module eeverify_ctrl #(
  parameter int unsigned WORDS = 1024,
  parameter int unsigned DW    = 16,
  parameter int unsigned OVH   = 14,
  localparam int unsigned AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [1:0]    bus_sel,
  input  logic [7:0]    bus_wdata,
  input  logic          pre_we,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  output logic          stat_buf_empty,
  output logic          stat_done,
  output logic          stat_blank,
  output logic          stat_acc_err
);

  logic          scan_start;
  logic          scan_busy;
  logic          scan_fin;
  logic          scan_ok;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  eev_array #(.WORDS(WORDS), .DW(DW)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .pre_we   (pre_we),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
  );

  eev_scan #(.WORDS(WORDS), .DW(DW), .OVH(OVH)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (scan_start),
    .rd_data (rd_data),
    .rd_addr (rd_addr),
    .busy    (scan_busy),
    .fin     (scan_fin),
    .ok      (scan_ok)
  );

  eev_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .scan_busy (scan_busy),
    .scan_fin  (scan_fin),
    .scan_ok   (scan_ok),
    .start     (scan_start),
    .buf_empty (stat_buf_empty),
    .done      (stat_done),
    .blank     (stat_blank),
    .acc_err   (stat_acc_err)
  );

  AST_START_ONLY_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |-> (!scan_busy || scan_fin)); // R6

endmodule

// File: tb/test_eeverify_ctrl.sv
module test_eeverify_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NW  = 8;
  localparam int OVH = 14;
  localparam int AW  = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [1:0] bus_sel = 2'b00;
  logic [7:0] bus_wdata = 8'h00;
  logic pre_we = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [15:0] pre_data = '1;
  logic stat_buf_empty, stat_done, stat_blank, stat_acc_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  eeverify_ctrl #(.WORDS(NW), .DW(16), .OVH(OVH)) i_eeverify_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .stat_buf_empty(stat_buf_empty), .stat_done(stat_done),
    .stat_blank(stat_blank), .stat_acc_err(stat_acc_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic preload(input int a, input logic [15:0] d);
    @(negedge clk);
    pre_we = 1'b1; pre_addr = AW'(a); pre_data = d;
    @(negedge clk);
    pre_we = 1'b0;
  endtask

  // third write of the sequence, then time until done; returns cycles from launch edge
  task automatic go_and_time(input bit disturb, output int dt);
    int t0;
    wr(2'b10, 8'h80);
    t0 = cyc;
    check(!stat_buf_empty && !stat_done && !stat_blank, "R2 flags cleared at launch",
          {stat_buf_empty, stat_done, stat_blank}, 0);
    @(negedge clk);
    check(stat_buf_empty == 1'b1, "R5 buffer free one cycle after launch", stat_buf_empty, 1);
    if (disturb) begin
      wr(2'b10, 8'h80);
      wr(2'b10, 8'h00);
      wr(2'b10, 8'h10);
    end
    while (!stat_done && (cyc - t0) < 300) @(negedge clk);
    dt = cyc - t0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(stat_buf_empty == 1 && stat_done == 1, "R1 buf_empty/done after reset",
          {stat_buf_empty, stat_done}, 3);
    check(stat_blank == 0 && stat_acc_err == 0, "R1 blank/acc_err after reset",
          {stat_blank, stat_acc_err}, 0);

    // R7 command write without array write
    wr(2'b01, 8'h05);
    check(stat_acc_err == 1, "R7 orphan command sets acc_err", stat_acc_err, 1);
    check(stat_buf_empty == 1, "R7 orphan command leaves buffer", stat_buf_empty, 1);
    wr(2'b10, 8'h80);
    check(stat_buf_empty == 1 && stat_done == 1, "R7 launch after orphan ignored",
          {stat_buf_empty, stat_done}, 3);
    // R9 write-one-to-clear
    wr(2'b10, 8'h00);
    check(stat_acc_err == 1, "R9 zero write keeps acc_err", stat_acc_err, 1);
    wr(2'b10, 8'h10);
    check(stat_acc_err == 0, "R9 one write clears acc_err", stat_acc_err, 0);

    // R7 unsupported code after array write; R10 array write with zero data
    wr(2'b00, 8'h00);
    wr(2'b01, 8'h06);
    check(stat_acc_err == 1, "R7 bad code sets acc_err", stat_acc_err, 1);
    wr(2'b10, 8'h80);
    check(stat_buf_empty == 1 && stat_done == 1, "R7 launch after bad code ignored",
          {stat_buf_empty, stat_done}, 3);
    wr(2'b10, 8'h10);
    // R8 zero in launch bit does nothing
    wr(2'b01, 8'h05);
    wr(2'b10, 8'h00);
    check(stat_buf_empty == 1 && stat_done == 1, "R8 zero launch bit no effect",
          {stat_buf_empty, stat_done}, 3);
    go_and_time(1'b0, dt);
    check(dt == NW + OVH, "R3 blank array completion cycles", dt, NW + OVH);
    check(stat_blank == 1, "R3 R10 blank after bus array writes", stat_blank, 1);

    // R4 R11 sweep of first programmed word position
    for (int i = 0; i < NW; i++) begin
      logic [15:0] pat;
      pat = (i % 2 == 0) ? 16'h0000 : (16'hFFFF ^ (16'h1 << i));
      preload(i, pat);
      if (i < NW - 1) preload(NW - 1, 16'h1234);
      wr(2'b00, 8'hA5);
      wr(2'b01, 8'h05);
      go_and_time(1'b0, dt);
      check(dt == OVH + i + 1, "R4 R11 early stop completion cycles", dt, OVH + i + 1);
      check(stat_blank == 0, "R4 blank stays clear on miss", stat_blank, 0);
      preload(i, 16'hFFFF);
      preload(NW - 1, 16'hFFFF);
    end

    // R8 status writes during the scan
    wr(2'b00, 8'hFF);
    wr(2'b01, 8'h05);
    go_and_time(1'b1, dt);
    check(dt == NW + OVH, "R8 disturbed scan completion cycles", dt, NW + OVH);
    check(stat_blank == 1, "R8 disturbed scan result", stat_blank, 1);

    // R6 buffered second command
    begin
      int ta;
      wr(2'b00, 8'h00);
      wr(2'b01, 8'h05);
      wr(2'b10, 8'h80);
      ta = cyc;
      @(negedge clk);
      check(stat_buf_empty == 1, "R5 buffer free for second sequence", stat_buf_empty, 1);
      wr(2'b00, 8'h00);
      wr(2'b01, 8'h05);
      wr(2'b10, 8'h80);
      check(stat_buf_empty == 0 && stat_done == 0, "R6 second launch held",
            {stat_buf_empty, stat_done}, 0);
      @(negedge clk);
      check(stat_buf_empty == 0, "R6 buffer stays busy while held", stat_buf_empty, 0);
      while (!stat_done && (cyc - ta) < 300) @(negedge clk);
      dt = cyc - ta;
      check(dt == 2 * (NW + OVH), "R6 back-to-back completion cycles", dt, 2 * (NW + OVH));
      check(stat_blank == 1 && stat_buf_empty == 1, "R6 final flags",
            {stat_blank, stat_buf_empty}, 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule